// File: doc/BRIEF.md
# Delay Line Bit Regenerator

This block keeps a bit stream alive as it circulates through an ultrasonic delay line memory. The line cannot carry a DC level, so each bit is sent as on/off keyed carrier: a one is a burst of carrier pulses and a zero is silence. After the trip through the line, the pulses return inverted, smeared and shortened. If they were fed straight back in, they would fade away after a few passes.

The regenerator runs on one oversampling clock. An internal timing generator derives the carrier and the bit clock from that clock. The raw line output is brought into the clock domain through a two-flop synchronizer. A sticky detector is set by any low sample seen inside a bit window. At the end of the window its value is captured as the recovered bit, and the detector is cleared for the next window.

The recovered bit, or an external write bit when writing is enabled, becomes the bit that is transmitted during the following window. The drive output is the carrier gated by that bit. Whatever shape the received pulses have, each pass through the block sends out full, clean carrier bursts aligned to the bit clock.

Top module: `dl_regen`

## Requirements
- R1: `drive` is high only while both `carrier` and the bit being transmitted are high. A transmitted one gives one carrier-shaped pulse per carrier period, and a transmitted zero leaves `drive` low for the whole window.
- R2: `carrier` has a period of OSR clocks and is high for the first OSR/2 of them. A bit window lasts PPB carrier periods (16 clocks by default). `bit_clk` is high for the first half of each window.
- R3: `line_n` is active low. A window in which `line_n` stays high recovers as 0.
- R4: A single low sample of `line_n`, lasting one clock, is enough to recover a 1 for its window. A burst of several pulses also recovers a 1.
- R5: The detector is cleared at every window boundary. A 1 in one window does not carry over into a following window that has no pulses.
- R6: `rec_bit` changes only at the last clock edge of a window and then holds its value for the whole next window.
- R7: With `wr_en` low at the end of a window, the bit transmitted in the next window equals the bit recovered from the current window.
- R8: With `wr_en` high at the end of a window, the next window transmits `wr_data`, whatever `line_n` did. `rec_bit` is still updated from the line.
- R9: During and right after reset, `rec_bit` and `drive` are 0, and `carrier` and `bit_clk` are 1. The first window after reset transmits 0.
- R10: `line_n` reaches the detector two clocks after it is sampled. A low in the last two clocks of a window is therefore counted in the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OSR clocks per carrier period |
| rst_n | input | 1 | Active-low synchronous reset |
| line_n | input | 1 | Raw, asynchronous, active-low delay line output |
| wr_en | input | 1 | Selects external write data as the next transmitted bit |
| wr_data | input | 1 | Bit to transmit when wr_en is high |
| drive | output | 1 | On/off keyed carrier that drives the line |
| carrier | output | 1 | Carrier derived from clk |
| bit_clk | output | 1 | Bit clock, high in the first half of each window |
| rec_bit | output | 1 | Recovered and retimed bit of the previous window |

## Verification
A detector that fails to clear would show up at `rec_bit` one window later, as a 1 after an idle window. A wrong synchronizer depth would shift pulses placed near a window edge into the wrong window, which is also visible one window later. A wrong transmit select appears at `drive` on the first carrier phase of the very next window. Timing counter errors show up within one window, through `bit_clk` and the carrier phase seen at fixed offsets.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // carrier is high in the first half of its period
  function automatic logic carrier_high(input int phase, input int osr);
    return phase < (osr / 2);
  endfunction

  // bit clock is high in the first half of the window
  function automatic logic bitclk_high(input int pcnt, input int ppb);
    return pcnt < (ppb / 2);
  endfunction

  // next transmitted bit
  function automatic logic next_tx(input logic wr_en, input logic wr_data,
                                   input logic seen);
    return wr_en ? wr_data : seen;
  endfunction

endpackage

// File: rtl/dl_timing.sv
module dl_timing #(
  parameter int OSR = 4,
  parameter int PPB = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic carrier,
  output logic bit_clk,
  output logic bit_end
);
  localparam int PH_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int PC_W = (PPB > 1) ? $clog2(PPB) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PPB - 1);

  logic [PH_W-1:0] phase_q;
  logic [PC_W-1:0] pcnt_q;
  logic            phase_wrap;

  assign phase_wrap = (phase_q == PH_LAST);
  assign bit_end    = phase_wrap && (pcnt_q == PC_LAST);
  assign carrier    = dl_pkg::carrier_high(int'(phase_q), OSR);
  assign bit_clk    = dl_pkg::bitclk_high(int'(pcnt_q), PPB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      pcnt_q  <= '0;
    end else begin
      phase_q <= phase_wrap ? '0 : phase_q + 1'b1;
      if (phase_wrap) pcnt_q <= (pcnt_q == PC_LAST) ? '0 : pcnt_q + 1'b1;
    end
  end

  // R2: a window ends and the next one starts with bit_clk high
  p_bitclk_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> bit_clk);
  // R2: carrier stays high for at least two clocks
  p_carrier_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier) |=> carrier);
  // R2: carrier is high at every window start
  p_carrier_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> carrier);
endmodule

// File: rtl/dl_sync.sv
module dl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic hit
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= line_n;
      s2_q <= s1_q;
    end
  end

  assign hit = !s2_q;

  // R10: a low sample reaches the detector two clocks later
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !line_n |=> ##1 hit);
endmodule

// File: rtl/dl_detect.sv
module dl_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic bit_end,
  input  logic wr_en,
  input  logic wr_data,
  output logic rec_bit,
  output logic tx_bit
);
  logic latch_q, rec_q, tx_q, seen;

  assign seen = latch_q | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      rec_q   <= 1'b0;
      tx_q    <= 1'b0;
    end else begin
      latch_q <= bit_end ? 1'b0 : seen;
      if (bit_end) begin
        rec_q <= seen;
        tx_q  <= dl_pkg::next_tx(wr_en, wr_data, seen);
      end
    end
  end

  assign rec_bit = rec_q;
  assign tx_bit  = tx_q;

  // R5: detector cleared at the boundary
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> !latch_q);
  // R4: a pulse inside a window is held
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !bit_end) |=> latch_q);
  // R6: recovered bit holds between boundaries
  p_rec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_end |=> $stable(rec_q));
  // R7: recirculation sends the recovered bit
  p_recirc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && !wr_en) |=> (tx_q == rec_q));
  // R8: write path overrides the line
  p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && wr_en) |=> (tx_q == $past(wr_data)));
endmodule

// File: rtl/dl_regen.sv
module dl_regen #(
  parameter int OSR = 4,
  parameter int PPB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic wr_en,
  input  logic wr_data,
  output logic drive,
  output logic carrier,
  output logic bit_clk,
  output logic rec_bit
);
  logic bit_end, hit, tx_bit;

  dl_timing #(.OSR(OSR), .PPB(PPB)) u_timing (
    .clk(clk), .rst_n(rst_n), .carrier(carrier),
    .bit_clk(bit_clk), .bit_end(bit_end));

  dl_sync u_sync (.clk(clk), .rst_n(rst_n), .line_n(line_n), .hit(hit));

  dl_detect u_detect (
    .clk(clk), .rst_n(rst_n), .hit(hit), .bit_end(bit_end),
    .wr_en(wr_en), .wr_data(wr_data), .rec_bit(rec_bit), .tx_bit(tx_bit));

  assign drive = carrier & tx_bit;

  // R1: drive never rises while carrier is steady
  p_drive_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $rose(carrier) || $rose(tx_bit));
  // R1: a transmitted zero keeps drive low
  p_zero_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit |-> !drive);
endmodule

// File: tb/dl_regen_test.sv
module dl_regen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_n = 1'b1;
  logic wr_en = 1'b0;
  logic wr_data = 1'b0;
  logic drive, carrier, bit_clk, rec_bit;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic rec;
    logic tx;
    string tag;
  } item_t;
  item_t sb[$];
  logic [15:0] prev_mask = '0;

  always #5 clk = ~clk;

  dl_regen uut (.clk(clk), .rst_n(rst_n), .line_n(line_n), .wr_en(wr_en),
    .wr_data(wr_data), .drive(drive), .carrier(carrier),
    .bit_clk(bit_clk), .rec_bit(rec_bit));

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  // driver: one 16-clock window; mask bit j means line low in clock j
  task automatic send(input logic [15:0] mask, input logic we,
                      input logic wd, input string tag);
    item_t it;
    it.rec = (|mask[13:0]) | (|prev_mask[15:14]);
    it.tx  = we ? wd : it.rec;
    it.tag = tag;
    sb.push_back(it);
    prev_mask = mask;
    wr_en = we;
    wr_data = wd;
    for (int j = 0; j < 16; j++) begin
      line_n = ~mask[j];
      @(negedge clk);
    end
  endtask

  // monitor: compares at fixed offsets of each following window
  task automatic monitor();
    item_t it;
    repeat (16) @(negedge clk);
    forever begin
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(rec_bit, it.rec, {it.tag, " rec_bit"});
        check(drive, it.tx, {"R1 R7 R8 drive phase0 ", it.tag});
        repeat (2) @(negedge clk);
        check(drive, 1'b0, {"R1 drive low phase ", it.tag});
        repeat (6) @(negedge clk);
        check(bit_clk, 1'b0, {"R2 bit_clk second half ", it.tag});
        repeat (8) @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    check(rec_bit, 1'b0, "R9 rec_bit in reset");
    check(drive, 1'b0, "R9 drive in reset");
    check(carrier, 1'b1, "R9 carrier in reset");
    check(bit_clk, 1'b1, "R9 bit_clk in reset");
    @(negedge clk);
    rst_n = 1'b1;
    fork
      monitor();
    join_none
    send(16'h0000, 1'b0, 1'b0, "R3 idle");
    send(16'h0020, 1'b0, 1'b0, "R4 single pulse");
    send(16'h3333, 1'b0, 1'b0, "R4 burst");
    send(16'h0000, 1'b0, 1'b0, "R5 cleared");
    send(16'h4000, 1'b0, 1'b0, "R10 late pulse own window");
    send(16'h0000, 1'b0, 1'b0, "R10 late pulse next window");
    send(16'h0000, 1'b1, 1'b1, "R8 write one");
    send(16'h3333, 1'b1, 1'b0, "R8 write zero");
    send(16'h0001, 1'b0, 1'b0, "R7 first clock pulse");
    send(16'hA000, 1'b0, 1'b0, "R6 pulses at edge");
    send(16'h0000, 1'b0, 1'b0, "R10 carry of last clock");
    send(16'h0000, 1'b0, 1'b0, "R5 idle after carry");
    line_n = 1'b1;
    wr_en = 1'b0;
    wait (sb.size() == 0);
    repeat (20) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule